// File: doc/BRIEF.md
# PCI Configuration Access Router

This block is the configuration access unit of a host bridge. It accepts single-beat reads and writes from a 32-bit memory-mapped request stream. Each request targets one of two spaces. The first is the bridge's register region. Within that region, low offsets hold a configuration-address register and high offsets form a configuration-data window. The second space is a 64 KB I/O window whose accesses go to an external responder.

A data-window access is routed by the fields of the configuration-address register. The enable bit must be set and the bus field must be zero. Device 0, function 0 reaches the bridge's own 256-byte header, which is stored big-endian. Every other device/function pair goes out on a device request port, but only when the device-present vector shows that device.

Requests and responses both use valid/ready. A request is taken only when `req_ready` is high, and `req_ready` stays low from acceptance until the response beat has been consumed. A response stays on `rsp_valid`/`rsp_rdata` unchanged while `rsp_ready` is low. The device and I/O request ports hold their request until the far side acknowledges it. Every accepted request, read or write, produces exactly one response beat. For writes that beat carries zero.

Top module: `cfg_access_router`

## Requirements
- R1: With `req_space`=0, an offset below 0x200000 selects the address register. A write there stores all 32 bits of `req_wdata`, and a read there returns zero.
- R2: While bit 7 (enable) of the address register is 0, configuration-data window accesses leave all state unchanged and reads return zero.
- R3: With enable set and bits 15:8 (bus) nonzero, a data-window read returns zero and a write is discarded. `err_pulse` is high for exactly one cycle.
- R4: The device number is taken from bits 23:19 of the address register and the function from bits 18:16. The register offset is bits 31:24 with bits 25:24 forced to zero.
- R5: Device 0, function 0 accesses the internal header. A write of size 2 or 4 puts its most significant byte at the lowest offset, and reads assemble bytes in the same big-endian order.
- R6: Any other device/function pair whose `dev_present` bit is set raises `dev_req_valid` and holds the request until `dev_ack`. A read then returns `dev_rdata`.
- R7: An access to a device whose `dev_present` bit is clear raises no device request. A read returns zero, a write is dropped, and `err_pulse` pulses.
- R8: A data-window access with `req_size` other than 1, 2 or 4 leaves the header unchanged, returns zero and pulses `err_pulse`.
- R9: With `req_space`=1, the request goes out on the I/O port. `io_ack` returns `io_rdata`, while `io_nak` returns zero and pulses `unmapped_pulse`.
- R10: `req_ready` is low from acceptance until the response is consumed. While `rsp_ready` is low, the response holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_space | input | 1 | 0 register region, 1 I/O window |
| req_write | input | 1 | 1 write, 0 read |
| req_offset | input | 22 | Byte offset inside the selected space |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Read data, zero for writes |
| dev_req_valid | output | 1 | Device configuration request |
| dev_req_write | output | 1 | Device request direction |
| dev_req_num | output | 5 | Target device number |
| dev_req_func | output | 3 | Target function number |
| dev_req_reg | output | 8 | Register offset, 4-byte aligned |
| dev_req_size | output | 3 | Access size |
| dev_req_wdata | output | 32 | Write data |
| dev_present | input | 32 | One bit per device number |
| dev_ack | input | 1 | Device completed the request |
| dev_rdata | input | 32 | Device read data |
| io_req_valid | output | 1 | I/O window request |
| io_req_write | output | 1 | I/O request direction |
| io_req_addr | output | 16 | Offset in the I/O window |
| io_req_size | output | 3 | Access size |
| io_req_wdata | output | 32 | Write data |
| io_ack | input | 1 | Responder accepted |
| io_nak | input | 1 | No responder claims the access |
| io_rdata | input | 32 | I/O read data |
| err_pulse | output | 1 | One-cycle configuration error flag |
| unmapped_pulse | output | 1 | One-cycle unmapped I/O flag |

## Verification
The hardest situations to reach from the ports are the silent ones. A disabled access, a nonzero bus field or an illegal size must leave the header exactly as it was, and the response alone cannot show that. The stimulus therefore first writes a known big-endian pattern into the header. It then issues each rejected write. Afterwards it re-enables a legal address and reads the same word back. The stimulus also writes an offset with its two low bits set, then checks the offset that appears on the device port, to show those bits are forced to zero.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  localparam int HDR_BYTES = 256;

  typedef enum logic [1:0] {ST_IDLE, ST_DEV, ST_IO, ST_RESP} rtr_state_t;

  typedef enum logic [2:0] {
    ACT_ADDR_WR, ACT_ZERO, ACT_ERR, ACT_HDR, ACT_DEV, ACT_IO
  } rtr_action_t;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [7:0] reg_off;
  } cfg_fields_t;

  function automatic logic size_legal(logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  // bit position of byte k of a big-endian access of size sz
  function automatic int lane_shift(logic [2:0] sz, int k);
    int sh;
    sh = 8 * (int'(sz) - 1 - k);
    if (sh < 0) sh = 0;
    if (sh > 24) sh = 24;
    return sh;
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_router_pkg::*;
(
  input  logic [31:0] cfg_addr,
  output cfg_fields_t fields,
  output logic        own_hdr
);
  logic unused_addr_bits;

  always_comb begin
    fields.en      = cfg_addr[7];
    fields.bus     = cfg_addr[15:8];
    fields.dev     = cfg_addr[23:19];
    fields.fn      = cfg_addr[18:16];
    fields.reg_off = {cfg_addr[31:26], 2'b00};
    own_hdr        = (fields.dev == 5'd0) && (fields.fn == 3'd0);
  end

  assign unused_addr_bits = ^{cfg_addr[6:0], cfg_addr[25:24]};
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  offset,
  input  logic [2:0]  size,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic [7:0] mem [HDR_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HDR_BYTES; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      for (int k = 0; k < 4; k++) begin
        if (k < int'(size))
          mem[offset + 8'(k)] <= wdata[lane_shift(size, k) +: 8];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (size_legal(size)) begin
      for (int k = 0; k < 4; k++) begin
        if (k < int'(size))
          rdata[lane_shift(size, k) +: 8] = mem[offset + 8'(k)];
      end
    end
  end

  // R8
  hdr_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> size_legal(size));
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfg_router_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int IO_W      = 16,
  parameter int NUM_DEV   = 32,
  parameter int DATA_SPLIT = 32'h0020_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_space,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_offset,
  input  logic [2:0]          req_size,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [31:0]         rsp_rdata,
  output logic                dev_req_valid,
  output logic                dev_req_write,
  output logic [4:0]          dev_req_num,
  output logic [2:0]          dev_req_func,
  output logic [7:0]          dev_req_reg,
  output logic [2:0]          dev_req_size,
  output logic [31:0]         dev_req_wdata,
  input  logic [NUM_DEV-1:0]  dev_present,
  input  logic                dev_ack,
  input  logic [31:0]         dev_rdata,
  output logic                io_req_valid,
  output logic                io_req_write,
  output logic [IO_W-1:0]     io_req_addr,
  output logic [2:0]          io_req_size,
  output logic [31:0]         io_req_wdata,
  input  logic                io_ack,
  input  logic                io_nak,
  input  logic [31:0]         io_rdata,
  output logic                err_pulse,
  output logic                unmapped_pulse
);
  localparam logic [ADDR_W-1:0] SPLIT_OFF = ADDR_W'(DATA_SPLIT);

  rtr_state_t  state;
  rtr_action_t act;
  cfg_fields_t fld;
  logic        own_hdr;
  logic [31:0] cfg_addr;
  logic [31:0] hdr_rdata;
  logic        hdr_wr;
  logic        accept;
  logic        in_data_win;

  cfg_addr_decode u_dec (
    .cfg_addr (cfg_addr),
    .fields   (fld),
    .own_hdr  (own_hdr)
  );

  cfg_hdr_regs u_hdr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (hdr_wr),
    .offset (fld.reg_off),
    .size   (req_size),
    .wdata  (req_wdata),
    .rdata  (hdr_rdata)
  );

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_RESP);
  assign accept      = req_valid && req_ready;
  assign in_data_win = (req_offset >= SPLIT_OFF);
  assign hdr_wr      = accept && (act == ACT_HDR) && req_write;

  always_comb begin
    if (req_space)                                  act = ACT_IO;
    else if (!in_data_win)                          act = req_write ? ACT_ADDR_WR : ACT_ZERO;
    else if (!fld.en)                               act = ACT_ZERO;
    else if (fld.bus != 8'd0 || !size_legal(req_size)) act = ACT_ERR;
    else if (own_hdr)                               act = ACT_HDR;
    else if (!dev_present[fld.dev])                 act = ACT_ERR;
    else                                            act = ACT_DEV;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      cfg_addr       <= '0;
      rsp_rdata      <= '0;
      err_pulse      <= 1'b0;
      unmapped_pulse <= 1'b0;
      dev_req_valid  <= 1'b0;
      dev_req_write  <= 1'b0;
      dev_req_num    <= '0;
      dev_req_func   <= '0;
      dev_req_reg    <= '0;
      dev_req_size   <= '0;
      dev_req_wdata  <= '0;
      io_req_valid   <= 1'b0;
      io_req_write   <= 1'b0;
      io_req_addr    <= '0;
      io_req_size    <= '0;
      io_req_wdata   <= '0;
    end else begin
      err_pulse      <= 1'b0;
      unmapped_pulse <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          rsp_rdata <= '0;
          unique case (act)
            ACT_ADDR_WR: begin cfg_addr <= req_wdata; state <= ST_RESP; end
            ACT_ZERO:    state <= ST_RESP;
            ACT_ERR:     begin err_pulse <= 1'b1; state <= ST_RESP; end
            ACT_HDR: begin
              if (!req_write) rsp_rdata <= hdr_rdata;
              state <= ST_RESP;
            end
            ACT_DEV: begin
              dev_req_valid <= 1'b1;
              dev_req_write <= req_write;
              dev_req_num   <= fld.dev;
              dev_req_func  <= fld.fn;
              dev_req_reg   <= fld.reg_off;
              dev_req_size  <= req_size;
              dev_req_wdata <= req_wdata;
              state         <= ST_DEV;
            end
            default: begin
              io_req_valid <= 1'b1;
              io_req_write <= req_write;
              io_req_addr  <= req_offset[IO_W-1:0];
              io_req_size  <= req_size;
              io_req_wdata <= req_wdata;
              state        <= ST_IO;
            end
          endcase
        end
        ST_DEV: if (dev_ack) begin
          dev_req_valid <= 1'b0;
          rsp_rdata     <= dev_req_write ? 32'd0 : dev_rdata;
          state         <= ST_RESP;
        end
        ST_IO: begin
          if (io_ack) begin
            io_req_valid <= 1'b0;
            rsp_rdata    <= io_req_write ? 32'd0 : io_rdata;
            state        <= ST_RESP;
          end else if (io_nak) begin
            io_req_valid   <= 1'b0;
            unmapped_pulse <= 1'b1;
            state          <= ST_RESP;
          end
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !dev_req_valid && !io_req_valid);
  // R6
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req_valid && !dev_ack |=> dev_req_valid && $stable(dev_req_num));
  // R7
  dev_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_req_valid) |-> dev_present[dev_req_num]);
  // R3
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
  // R9
  io_unmap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_pulse |-> rsp_valid && (rsp_rdata == 32'd0));
endmodule

// File: tb/cfg_access_router_tb_top.sv
`timescale 1ns/1ps
module cfg_access_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_space = 0, req_write = 0, rsp_ready = 1;
  logic [21:0] req_offset = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        dev_req_valid, dev_req_write;
  logic [4:0]  dev_req_num;
  logic [2:0]  dev_req_func, dev_req_size, io_req_size;
  logic [7:0]  dev_req_reg;
  logic [31:0] dev_req_wdata, io_req_wdata;
  logic [31:0] dev_present = '0;
  logic        dev_ack = 0, io_ack = 0, io_nak = 0;
  logic [31:0] dev_rdata = '0, io_rdata = '0;
  logic        io_req_valid, io_req_write;
  logic [15:0] io_req_addr;
  logic        err_pulse, unmapped_pulse;

  cfg_access_router dut_i (.*);

  int n_checks = 0, n_fail = 0, err_cnt = 0, unmap_cnt = 0, dev_cnt = 0;
  bit io_accept = 1, done = 0;
  int dev_wait = 0;
  logic [7:0]  last_reg;
  logic [4:0]  last_num;
  logic [2:0]  last_fn;
  logic [31:0] last_wd;

  always @(posedge clk) begin
    if (err_pulse) err_cnt <= err_cnt + 1;
    if (unmapped_pulse) unmap_cnt <= unmap_cnt + 1;
  end

  // device responder: acknowledges two cycles after it sees a request
  always @(posedge clk) begin
    if (dev_ack) begin
      dev_ack <= 0; dev_wait <= 0;
    end else if (dev_req_valid) begin
      if (dev_wait == 1) begin
        dev_ack   <= 1;
        dev_rdata <= {8'hD0, dev_req_reg, 5'd0, dev_req_func, 3'd0, dev_req_num};
        last_reg  <= dev_req_reg; last_num <= dev_req_num;
        last_fn   <= dev_req_func; last_wd <= dev_req_wdata;
        dev_cnt   <= dev_cnt + 1;
      end
      dev_wait <= dev_wait + 1;
    end
  end

  // I/O responder: one cycle latency
  always @(posedge clk) begin
    io_ack <= 0; io_nak <= 0;
    if (io_req_valid && !io_ack && !io_nak) begin
      if (io_accept) begin io_ack <= 1; io_rdata <= {16'hB0B0, io_req_addr}; end
      else io_nak <= 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic xact(input bit sp, input bit wr, input logic [21:0] off,
                      input logic [31:0] wd, input logic [2:0] sz, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_space = sp; req_write = wr; req_offset = off;
    req_wdata = wd; req_size = sz;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 0;
    do @(negedge clk); while (!rsp_valid);
    rd = rsp_rdata;
    @(posedge clk);
    @(negedge clk);
  endtask

  localparam logic [21:0] DWIN = 22'h200000;

  function automatic logic [31:0] caddr(bit en, logic [7:0] bus, logic [4:0] dv,
                                        logic [2:0] fn, logic [7:0] rg);
    return {rg, dv, fn, bus, en, 7'd0};
  endfunction

  task automatic set_addr(input logic [31:0] v);
    logic [31:0] rd;
    xact(0, 1, 22'h0, v, 3'd4, rd);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 reset ready", {31'd0, req_ready}, 32'd1);
    check("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R10 reset err", {31'd0, err_pulse}, 32'd0);
  endtask

  task automatic t_addr_window;
    logic [31:0] rd;
    set_addr(caddr(1, 0, 0, 0, 8'h10));
    xact(0, 0, 22'h000040, 0, 3'd4, rd);
    check("R1 address window read", rd, 32'd0);
  endtask

  task automatic t_header;
    logic [31:0] rd;
    set_addr(caddr(1, 0, 0, 0, 8'h10));
    xact(0, 1, DWIN, 32'h11223344, 3'd4, rd);
    xact(0, 0, DWIN, 0, 3'd4, rd);  check("R5 word read", rd, 32'h11223344);
    xact(0, 0, DWIN, 0, 3'd1, rd);  check("R5 byte read msb first", rd, 32'h11);
    xact(0, 0, DWIN, 0, 3'd2, rd);  check("R5 half read", rd, 32'h1122);
    set_addr(caddr(1, 0, 0, 0, 8'h13));
    xact(0, 0, DWIN, 0, 3'd1, rd);  check("R4 low offset bits forced", rd, 32'h11);
    set_addr(caddr(1, 0, 0, 0, 8'h20));
    xact(0, 1, DWIN, 32'h0000AABB, 3'd2, rd);
    xact(0, 0, DWIN, 0, 3'd4, rd);  check("R5 half write layout", rd, 32'hAABB0000);
  endtask

  task automatic t_disabled;
    logic [31:0] rd;
    int e0 = err_cnt;
    set_addr(caddr(0, 0, 0, 0, 8'h10));
    xact(0, 1, DWIN, 32'hDEADBEEF, 3'd4, rd);
    xact(0, 0, DWIN, 0, 3'd4, rd);  check("R2 disabled read", rd, 32'd0);
    set_addr(caddr(1, 0, 0, 0, 8'h10));
    xact(0, 0, DWIN, 0, 3'd4, rd);  check("R2 header untouched", rd, 32'h11223344);
    check("R2 no error", err_cnt, e0);
  endtask

  task automatic t_bus;
    logic [31:0] rd;
    int e0 = err_cnt;
    set_addr(caddr(1, 8'h01, 0, 0, 8'h10));
    xact(0, 0, DWIN, 0, 3'd4, rd);  check("R3 bus read zero", rd, 32'd0);
    check("R3 error pulse", err_cnt, e0 + 1);
    xact(0, 1, DWIN, 32'h55555555, 3'd4, rd);
    set_addr(caddr(1, 0, 0, 0, 8'h10));
    xact(0, 0, DWIN, 0, 3'd4, rd);  check("R3 write discarded", rd, 32'h11223344);
  endtask

  task automatic t_bad_size;
    logic [31:0] rd;
    int e0 = err_cnt;
    xact(0, 1, DWIN, 32'h99999999, 3'd3, rd);
    check("R8 error pulse", err_cnt, e0 + 1);
    xact(0, 0, DWIN, 0, 3'd3, rd);  check("R8 read zero", rd, 32'd0);
    xact(0, 0, DWIN, 0, 3'd4, rd);  check("R8 header untouched", rd, 32'h11223344);
  endtask

  task automatic t_device;
    logic [31:0] rd;
    dev_present = 32'h0000_0021;
    set_addr(caddr(1, 0, 5'd5, 3'd2, 8'h27));
    xact(0, 0, DWIN, 0, 3'd4, rd);  check("R6 device read data", rd, 32'hD0240205);
    check("R4 device reg", {24'd0, last_reg}, 32'h24);
    check("R4 device num", {27'd0, last_num}, 32'd5);
    check("R4 device func", {29'd0, last_fn}, 32'd2);
    xact(0, 1, DWIN, 32'hCAFEF00D, 3'd4, rd);
    check("R6 device write data", last_wd, 32'hCAFEF00D);
    set_addr(caddr(1, 0, 5'd0, 3'd1, 8'h08));
    xact(0, 0, DWIN, 0, 3'd4, rd);  check("R6 dev0 func1 external", rd, 32'hD0080100);
  endtask

  task automatic t_absent;
    logic [31:0] rd;
    int e0 = err_cnt, d0 = dev_cnt;
    set_addr(caddr(1, 0, 5'd7, 3'd0, 8'h00));
    xact(0, 0, DWIN, 0, 3'd4, rd);  check("R7 absent read zero", rd, 32'd0);
    check("R7 error pulse", err_cnt, e0 + 1);
    check("R7 no device request", dev_cnt, d0);
  endtask

  task automatic t_io;
    logic [31:0] rd;
    int u0 = unmap_cnt;
    io_accept = 1;
    xact(1, 0, 22'h001234, 0, 3'd2, rd); check("R9 io read", rd, 32'hB0B01234);
    io_accept = 0;
    xact(1, 0, 22'h000010, 0, 3'd4, rd); check("R9 unmapped read zero", rd, 32'd0);
    check("R9 unmapped pulse", unmap_cnt, u0 + 1);
    io_accept = 1;
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    set_addr(caddr(1, 0, 0, 0, 8'h10));
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_space = 0; req_write = 0; req_offset = DWIN; req_size = 3'd4;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk); held = rsp_rdata;
    repeat (3) @(negedge clk);
    check("R10 response held", {31'd0, rsp_valid}, 32'd1);
    check("R10 data stable", rsp_rdata, held);
    check("R10 ready low while pending", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1;
    @(negedge clk);
    check("R10 released", {30'd0, rsp_valid, req_ready}, 32'd1);
    check("R10 held data value", held, 32'h11223344);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_addr_window();
    t_header();
    t_disabled();
    t_bus();
    t_bad_size();
    t_device();
    t_absent();
    t_io();
    t_backpressure();
    summary();
  end
endmodule